// File: doc/BRIEF.md
# MMC Command Line Engine

This block moves one host command across the single-bit command wire of a MultiMedia Card bus and, when asked, collects the card's reply. A control unit writes an enable bit once. For each command it then writes a command word: a 6-bit index, a 32-bit argument, the reply kind and the line-drive mode. The engine builds a 48-bit frame and adds a CRC7 to it. It shifts the frame out one bit per card-clock rising edge and then releases the wire. After that it hunts for the card's start bit and captures either a 48-bit or a 136-bit reply.

The card clock itself is generated elsewhere. The engine sees it as `clk_rise`, a one-cycle strobe on the system clock that marks each rising edge of the card clock. The engine both drives and samples the wire on these strobes. Each command picks its own drive mode. Push-pull drives every bit. Open-drain only pulls the wire low and leaves the external pull-up to make the ones, which is what the identification phase needs when several cards share the wire. Completion is reported by a one-cycle `done` pulse. Two status flags, reply timeout and reply CRC error, stay valid until the next command is accepted.

Top module: `mmc_cmd_engine`

## Requirements
- R1: After reset the engine is disabled: `busy` and `done` are 0 and `cmd_oe` is 0. Command writes are ignored until `en_wr` has written `en_val`=1.
- R2: An accepted command appears on the wire with one bit per `clk_rise`, most significant bit first, in this order: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, 7 CRC bits, and a 1 end bit.
- R3: The CRC is CRC7 with generator x^7+x^3+1 and a zero seed, taken over the first 40 frame bits. For index 0 with argument 0 the frame is 48'h400000000095.
- R4: In push-pull mode (`open_drain`=0) `cmd_oe` is 1 for all 48 frame bits. In open-drain mode `cmd_oe` is 1 exactly while a 0 is driven. Outside a frame, the wire is released (`cmd_oe`=0) from the first `clk_rise` after the end bit.
- R5: `busy` is 1 from the cycle after an accepted write until `done`. A write while `busy` has no effect on the frame in flight.
- R6: `rsp_type` 0 means no reply, 1 means a 48-bit reply, and 2 or 3 mean a 136-bit reply. With no reply, `done` follows the `clk_rise` after the end bit.
- R7: After the end bit, the first 0 sampled on `cmd_in` is the reply start bit. That bit and the following bits, 48 or 136 in total, land MSB-first in the low bits of `rsp_data`. The upper bits of `rsp_data` are zero.
- R8: A start bit sampled on any of the first 64 `clk_rise` strobes after the end bit is accepted. If none is seen by the 64th strobe, `rsp_timeout` is set and `done` follows.
- R9: For a 48-bit reply, `rsp_crc_err` is set when reply bits [7:1] differ from the CRC7 of bits [47:8]. For a 136-bit reply the check is skipped and `rsp_crc_err` stays 0.
- R10: `done` is a single-cycle pulse, high two system clocks after the `clk_rise` that samples the last reply bit or the 64th empty hunt strobe. Both status flags clear when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| cmd_wr | input | 1 | Command word write strobe; starts a command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | Reply kind: 0 none, 1 short, 2/3 long |
| open_drain | input | 1 | 1 selects open-drain drive for this command |
| clk_rise | input | 1 | Strobe marking a card-clock rising edge |
| cmd_in | input | 1 | Sampled level of the command wire |
| cmd_out | output | 1 | Value driven onto the command wire |
| cmd_oe | output | 1 | Output enable for the command wire |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | No reply start bit within the window |
| rsp_crc_err | output | 1 | Short reply failed its CRC7 check |
| rsp_data | output | 136 | Captured reply, right-aligned |

## Verification
The line value changes one system clock after each `clk_rise`. The bench therefore reads the wire at the falling edge just before the next strobe and sets the card's reply bit at that same point. The `done` pulse for a reply or a timeout is due two system clocks after the final sampling strobe. For a command without a reply it is due one clock after the strobe that follows the end bit. The bench checks `done` at the falling edges on each side of that expected edge. The 64-strobe hunt window is probed on both sides of its limit, with a start bit on the 64th strobe and with none at all. Expected frames and reply CRCs come from a polynomial long division in the bench, with arguments derived arithmetically from a sweep over all 64 command indices.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

  // Control sequencer of the engine
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SEND,
    ENG_DRAIN,
    ENG_RESP
  } eng_state_t;

  // Reply receiver phase
  typedef enum logic [1:0] {
    RX_OFF,
    RX_HUNT,
    RX_SHIFT
  } rx_phase_t;

  localparam int CRC_W   = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1, x^7 implicit

endpackage

// File: rtl/mmc_crc7_calc.sv
module mmc_crc7_calc
  import mmc_cmd_pkg::*;
#(
  parameter int N = 40
) (
  input  logic [N-1:0]     msg,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] acc;
  logic             fb;

  // Bit-serial division unrolled over the message, MSB first
  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      fb  = msg[i] ^ acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

  assign crc = acc;

endmodule

// File: rtl/mmc_cmd_tx.sv
module mmc_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rstn,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               od_sel,
  input  logic               tick,
  output logic               line_o,
  output logic               line_oe,
  output logic               last_bit
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               run_q, run_d;
  logic               od_q, od_d;
  logic               out_q, out_d;
  logic               oe_q, oe_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    run_d = run_q;
    od_d  = od_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (load) begin
      sr_d  = frame;
      cnt_d = '0;
      run_d = 1'b1;
      od_d  = od_sel;
    end else if (tick) begin
      if (run_q) begin
        out_d = sr_q[FRAME_W-1];
        oe_d  = od_q ? ~sr_q[FRAME_W-1] : 1'b1;
        sr_d  = {sr_q[FRAME_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_d = 1'b0;
        end
      end else begin
        out_d = 1'b1;
        oe_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      sr_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      od_q  <= 1'b0;
      out_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      od_q  <= od_d;
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign line_o   = out_q;
  assign line_oe  = oe_q;
  assign last_bit = run_q && tick && !load && (cnt_q == LAST);

  // R4: open-drain never actively drives a one
  p_od_zero_r4: assert property (@(posedge clk) disable iff (!rstn)
    (od_q && oe_q) |-> !out_q);

  // R4: idle strobes release the wire
  p_release_r4: assert property (@(posedge clk) disable iff (!rstn)
    (!run_q && tick && !load) |=> !oe_q);

  // R5: a new frame is never loaded over one in flight
  p_no_reload_r5: assert property (@(posedge clk) disable iff (!rstn)
    load |-> !run_q);

endmodule

// File: rtl/mmc_rsp_rx.sv
module mmc_rsp_rx
  import mmc_cmd_pkg::*;
#(
  parameter int LONG_W     = 136,
  parameter int SHORT_W    = 48,
  parameter int WAIT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              clr,
  input  logic              go,
  input  logic              long_sel,
  input  logic              tick,
  input  logic              line_i,
  output logic              fin,
  output logic              tmo,
  output logic              crc_bad,
  output logic [LONG_W-1:0] data
);

  localparam int WCNT_W = $clog2(WAIT_TICKS);
  localparam int BCNT_W = $clog2(LONG_W);
  localparam logic [WCNT_W-1:0] W_LAST = WCNT_W'(WAIT_TICKS - 1);
  localparam logic [BCNT_W-1:0] L_LAST = BCNT_W'(LONG_W - 1);
  localparam logic [BCNT_W-1:0] S_LAST = BCNT_W'(SHORT_W - 1);
  localparam int CHK_N = SHORT_W - CRC_W - 1;

  rx_phase_t         ph_q, ph_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [LONG_W-1:0] sr_q, sr_d, sr_nxt;
  logic              long_q, long_d;
  logic              fin_q, fin_d;
  logic              tmo_q, tmo_d;
  logic              bad_q, bad_d;
  logic [CRC_W-1:0]  crc_calc;

  assign sr_nxt = {sr_q[LONG_W-2:0], line_i};

  mmc_crc7_calc #(.N(CHK_N)) u_chk (
    .msg (sr_nxt[SHORT_W-1:CRC_W+1]),
    .crc (crc_calc)
  );

  always_comb begin
    ph_d   = ph_q;
    wcnt_d = wcnt_q;
    bcnt_d = bcnt_q;
    sr_d   = sr_q;
    long_d = long_q;
    tmo_d  = tmo_q;
    bad_d  = bad_q;
    fin_d  = 1'b0;
    if (clr) begin
      ph_d   = RX_OFF;
      sr_d   = '0;
      long_d = long_sel;
      tmo_d  = 1'b0;
      bad_d  = 1'b0;
    end else if (go) begin
      ph_d   = RX_HUNT;
      wcnt_d = '0;
    end else if (tick) begin
      case (ph_q)
        RX_HUNT: begin
          if (!line_i) begin
            sr_d   = sr_nxt;
            bcnt_d = BCNT_W'(1);
            ph_d   = RX_SHIFT;
          end else if (wcnt_q == W_LAST) begin
            tmo_d = 1'b1;
            fin_d = 1'b1;
            ph_d  = RX_OFF;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
        RX_SHIFT: begin
          sr_d   = sr_nxt;
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == (long_q ? L_LAST : S_LAST)) begin
            fin_d = 1'b1;
            ph_d  = RX_OFF;
            bad_d = !long_q && (crc_calc != sr_nxt[CRC_W:1]);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      ph_q   <= RX_OFF;
      wcnt_q <= '0;
      bcnt_q <= '0;
      sr_q   <= '0;
      long_q <= 1'b0;
      fin_q  <= 1'b0;
      tmo_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      wcnt_q <= wcnt_d;
      bcnt_q <= bcnt_d;
      sr_q   <= sr_d;
      long_q <= long_d;
      fin_q  <= fin_d;
      tmo_q  <= tmo_d;
      bad_q  <= bad_d;
    end
  end

  assign fin     = fin_q;
  assign tmo     = tmo_q;
  assign crc_bad = bad_q;
  assign data    = sr_q;

  // R8: a timeout always ends the reply phase
  p_tmo_fin_r8: assert property (@(posedge clk) disable iff (!rstn)
    $rose(tmo_q) |-> fin_q);

  // R9: long replies never report a CRC error
  p_long_nocrc_r9: assert property (@(posedge clk) disable iff (!rstn)
    (long_q && fin_q) |-> !bad_q);

endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
  import mmc_cmd_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int LONG_W     = 136,
  parameter int WAIT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              cmd_wr,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [1:0]        rsp_type,
  input  logic              open_drain,
  input  logic              clk_rise,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              done,
  output logic              rsp_timeout,
  output logic              rsp_crc_err,
  output logic [LONG_W-1:0] rsp_data
);

  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rstn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rstn = rs_q[1];

  eng_state_t st_q, st_d;
  logic       en_q, en_d;
  logic       exp_q, exp_d;
  logic       done_q, done_d;
  logic       accept;
  logic       tx_last, rx_fin, rx_go;

  logic [HDR_W-1:0]   hdr;
  logic [CRC_W-1:0]   hdr_crc;
  logic [FRAME_W-1:0] frame;

  assign accept = cmd_wr && en_q && (st_q == ENG_IDLE);
  assign hdr    = {2'b01, cmd_idx, cmd_arg};
  assign frame  = {hdr, hdr_crc, 1'b1};
  assign rx_go  = (st_q == ENG_SEND) && tx_last && exp_q;

  mmc_crc7_calc #(.N(HDR_W)) u_crc (
    .msg (hdr),
    .crc (hdr_crc)
  );

  mmc_cmd_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rstn     (rstn),
    .load     (accept),
    .frame    (frame),
    .od_sel   (open_drain),
    .tick     (clk_rise),
    .line_o   (cmd_out),
    .line_oe  (cmd_oe),
    .last_bit (tx_last)
  );

  mmc_rsp_rx #(
    .LONG_W     (LONG_W),
    .SHORT_W    (FRAME_W),
    .WAIT_TICKS (WAIT_TICKS)
  ) u_rx (
    .clk      (clk),
    .rstn     (rstn),
    .clr      (accept),
    .go       (rx_go),
    .long_sel (rsp_type[1]),
    .tick     (clk_rise),
    .line_i   (cmd_in),
    .fin      (rx_fin),
    .tmo      (rsp_timeout),
    .crc_bad  (rsp_crc_err),
    .data     (rsp_data)
  );

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    en_d   = en_wr ? en_val : en_q;
    exp_d  = accept ? (rsp_type != 2'd0) : exp_q;
    case (st_q)
      ENG_IDLE:  if (accept) st_d = ENG_SEND;
      ENG_SEND:  if (tx_last) st_d = exp_q ? ENG_RESP : ENG_DRAIN;
      ENG_DRAIN: if (clk_rise) begin
                   st_d   = ENG_IDLE;
                   done_d = 1'b1;
                 end
      ENG_RESP:  if (rx_fin) begin
                   st_d   = ENG_IDLE;
                   done_d = 1'b1;
                 end
      default:   st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      st_q   <= ENG_IDLE;
      en_q   <= 1'b0;
      exp_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      exp_q  <= exp_d;
      done_q <= done_d;
    end
  end

  assign busy = (st_q != ENG_IDLE);
  assign done = done_q;

  // R1: while disabled an idle engine stays idle
  p_locked_r1: assert property (@(posedge clk) disable iff (!rstn)
    (!en_q && st_q == ENG_IDLE) |=> (st_q == ENG_IDLE));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstn)
    done |=> !done);

  // R5: busy has dropped when completion is signalled
  p_busy_done_r5: assert property (@(posedge clk) disable iff (!rstn)
    done |-> !busy);

endmodule

// File: tb/sim_mmc_cmd_engine.sv
module sim_mmc_cmd_engine;

  localparam int LW = 136;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, en_wr, en_val, cmd_wr, open_drain, clk_rise, card_drv;
  logic [5:0]    cmd_idx;
  logic [31:0]   cmd_arg;
  logic [1:0]    rsp_type;
  logic          cmd_out, cmd_oe, busy, done, rsp_timeout, rsp_crc_err;
  logic [LW-1:0] rsp_data;
  logic          bus;

  assign bus = card_drv & (cmd_oe ? cmd_out : 1'b1);

  int n_cmp = 0;
  int n_bad = 0;

  mmc_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val), .cmd_wr(cmd_wr),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_type(rsp_type), .open_drain(open_drain),
    .clk_rise(clk_rise), .cmd_in(bus), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
    .done(done), .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err), .rsp_data(rsp_data)
  );

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) begin
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, ref_crc(h), 1'b1};
  endfunction

  function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] st);
    logic [39:0] h;
    h = {2'b00, idx, st};
    return {h, ref_crc(h), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Returns at a falling edge; the following rising edge is a card-clock strobe
  task automatic slot();
    @(negedge clk); clk_rise = 1'b0;
    @(negedge clk);
    @(negedge clk); clk_rise = 1'b1;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt, input logic od);
    @(negedge clk);
    clk_rise = 1'b0;
    cmd_idx = idx; cmd_arg = arg; rsp_type = rt; open_drain = od; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic grab(output logic [47:0] f, output bit oe_ok, input logic od);
    int n;
    f = '0; oe_ok = 1'b1; n = 0;
    slot();
    while (bus !== 1'b0 && n < 20) begin
      slot();
      n++;
    end
    for (int b = 47; b >= 0; b--) begin
      if (b != 47) slot();
      f[b] = bus;
      if (od) begin
        if (cmd_oe !== ~bus) oe_ok = 1'b0;
      end else if (cmd_oe !== 1'b1) begin
        oe_ok = 1'b0;
      end
    end
  endtask

  // Card reply: dly idle strobes, then len bits MSB first
  task automatic respond(input int dly, input logic [LW-1:0] bits, input int len);
    for (int t = 0; t < dly + len; t++) begin
      if (t > 0) slot();
      if (t == 1) chk(cmd_oe === 1'b0, "R4 wire released after end bit", cmd_oe, 0);
      card_drv = (t < dly) ? 1'b1 : bits[len - 1 - (t - dly)];
    end
  endtask

  task automatic end_reply(input string tag);
    logic d0, d1;
    @(negedge clk); clk_rise = 1'b0; card_drv = 1'b1; d0 = done;
    @(negedge clk); d1 = done;
    chk(!d0 && d1 && !busy, tag, {d0, d1, busy}, 3'b010);
    @(negedge clk);
    chk(done === 1'b0, "R10 done is one cycle", done, 0);
  endtask

  task automatic end_none(input string tag);
    @(negedge clk); clk_rise = 1'b0;
    chk(done === 1'b1 && busy === 1'b0 && cmd_oe === 1'b0, tag, {done, busy, cmd_oe}, 3'b100);
    @(negedge clk);
    chk(done === 1'b0, "R10 done is one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [47:0]   f, e, r;
    logic [LW-1:0] lr;
    bit            ok;
    logic [31:0]   a;
    bit            quiet;

    rst_n = 1'b0; en_wr = 1'b0; en_val = 1'b0; cmd_wr = 1'b0; open_drain = 1'b0;
    clk_rise = 1'b0; card_drv = 1'b1; cmd_idx = '0; cmd_arg = '0; rsp_type = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && cmd_oe === 1'b0, "R1 reset state",
        {busy, done, cmd_oe}, 3'b000);

    // R1 command ignored while disabled
    issue(6'd5, 32'h1234_5678, 2'd0, 1'b0);
    quiet = 1'b1;
    for (int k = 0; k < 8; k++) begin
      slot();
      if (busy !== 1'b0 || cmd_oe !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, "R1 write ignored while disabled", {busy, cmd_oe}, 2'b00);

    @(negedge clk); clk_rise = 1'b0; en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk); en_wr = 1'b0;

    // R3 known frame, R2 order, R4 push-pull
    issue(6'd0, 32'h0, 2'd0, 1'b0);
    chk(busy === 1'b1, "R5 busy after accept", busy, 1);
    grab(f, ok, 1'b0);
    chk(f === 48'h400000000095, "R3 frame of index 0", f, 48'h400000000095);
    chk(ok, "R4 push-pull enable on every bit", ok, 1);
    end_none("R6 no-reply completion");

    // R2 R3 R4 sweep over every index, alternating drive mode
    for (int i = 0; i < 64; i++) begin
      a = 32'(i) * 32'h9E37_79B1 ^ 32'hA5A5_0F0F;
      issue(6'(i), a, 2'd0, 1'(i % 2));
      grab(f, ok, 1'(i % 2));
      e = mk_cmd(6'(i), a);
      chk(f === e, "R2 frame content", f, e);
      chk(ok, "R4 enable pattern for mode", ok, 1);
      end_none("R6 no-reply completion");
    end

    // R5 write while busy is ignored
    issue(6'd17, 32'h0000_0200, 2'd0, 1'b0);
    issue(6'd24, 32'hFFFF_FFFF, 2'd0, 1'b1);
    chk(busy === 1'b1, "R5 busy holds", busy, 1);
    grab(f, ok, 1'b0);
    e = mk_cmd(6'd17, 32'h0000_0200);
    chk(f === e, "R5 second write left frame intact", f, e);
    end_none("R5 completion of first command");

    // R7 short reply, good CRC
    issue(6'd13, 32'h0001_0000, 2'd1, 1'b0);
    grab(f, ok, 1'b0);
    r = mk_short(6'd13, 32'h0000_0900);
    respond(2, {88'b0, r}, 48);
    end_reply("R10 done timing short reply");
    chk(rsp_data === {88'b0, r}, "R7 short reply data", rsp_data, {88'b0, r});
    chk(rsp_crc_err === 1'b0 && rsp_timeout === 1'b0, "R9 good CRC accepted",
        {rsp_crc_err, rsp_timeout}, 2'b00);

    // R9 short reply, corrupted CRC
    issue(6'd13, 32'h0001_0000, 2'd1, 1'b0);
    grab(f, ok, 1'b0);
    r = mk_short(6'd13, 32'hCAFE_0001) ^ 48'h0000_0000_0008;
    respond(3, {88'b0, r}, 48);
    end_reply("R10 done timing bad CRC");
    chk(rsp_crc_err === 1'b1, "R9 bad CRC flagged", rsp_crc_err, 1);

    // R6 R7 R9 broadcast identification with long reply, open-drain
    issue(6'd2, 32'h0, 2'd2, 1'b1);
    grab(f, ok, 1'b1);
    chk(f === mk_cmd(6'd2, 32'h0), "R2 broadcast frame", f, mk_cmd(6'd2, 32'h0));
    chk(ok, "R4 open-drain enable pattern", ok, 1);
    lr = {2'b00, 6'b111111, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 24'h765432, 7'h55, 1'b1};
    respond(2, lr, 136);
    end_reply("R10 done timing long reply");
    chk(rsp_data === lr, "R7 long reply data", rsp_data, lr);
    chk(rsp_crc_err === 1'b0, "R9 long reply skips CRC", rsp_crc_err, 0);

    // R8 start bit on the 64th hunt strobe is accepted (type 3 = long)
    issue(6'd9, 32'h0005_0000, 2'd3, 1'b0);
    grab(f, ok, 1'b0);
    lr = {2'b00, 6'b111111, 120'h0F0F_1E1E_2D2D_3C3C_4B4B_5A5A_6969_78, 7'h00, 1'b1};
    respond(63, lr, 136);
    end_reply("R10 done timing late reply");
    chk(rsp_timeout === 1'b0 && rsp_data === lr, "R8 late start accepted",
        {rsp_timeout, rsp_data[7:0]}, {1'b0, lr[7:0]});

    // R8 no start bit in 64 strobes: timeout
    issue(6'd55, 32'h0, 2'd1, 1'b0);
    grab(f, ok, 1'b0);
    for (int t = 0; t < 64; t++) begin
      if (t > 0) slot();
      card_drv = 1'b1;
    end
    end_reply("R10 done timing on timeout");
    chk(rsp_timeout === 1'b1, "R8 timeout raised", rsp_timeout, 1);

    // R10 status cleared by the next accepted command
    issue(6'd7, 32'h0000_0001, 2'd0, 1'b0);
    chk(rsp_timeout === 1'b0 && rsp_crc_err === 1'b0, "R10 flags clear on accept",
        {rsp_timeout, rsp_crc_err}, 2'b00);
    grab(f, ok, 1'b0);
    end_none("R6 no-reply completion");

    summary();
    $finish;
  end

endmodule